// File: doc/BRIEF.md
# Block Hilbert Transformer

This block produces the 90-degree phase-shifted companion of a block of real samples. It captures 16 signed samples from a valid/ready input stream and stores them in an internal complex register buffer. A single radix-2 butterfly engine then runs a forward transform over the buffer, entirely in place. Each frequency bin is then rotated a quarter turn, with the direction of the turn set by the sign of the bin's frequency. The same engine runs the inverse transform with conjugated twiddles. The real part of the result is streamed out in natural order, and a done pulse marks the last sample.

The forward pass halves every butterfly result with rounding, so the forward spectrum carries the full 1/N factor and cannot overflow. The inverse pass runs at unit gain in a buffer that has enough guard bits to hold its growth. Any output that still exceeds the 16-bit range is clamped. The block handles one frame at a time. While a frame is being computed or streamed out, the input side is closed.

Top module: `hilbert_fft`

## Requirements
- R1: While reset is asserted and immediately after it, inReady is 1, outValid is 0 and doneO is 0.
- R2: A sample is taken on every clock edge where inValid and inReady are both 1, and gaps with inValid low are skipped. After the 16th sample is taken, inReady stays 0 until the output stream ends, and it is 1 again in the cycle after the last output sample.
- R3: An output frame is exactly 16 consecutive cycles with outValid high, carrying samples n = 0..15 in natural order. doneO is high only together with sample n = 15.
- R4: For any input frame, each output sample equals the discrete Hilbert transform of the frame, computed as inverse DFT of -j·sgn(k)·DFT(x), within ±40 LSB. Bins 1..7 count as positive and bins 9..15 as negative.
- R5: An input of A·cos(2πmn/16) produces A·sin(2πmn/16) within the R4 tolerance.
- R6: Bin 0 (DC) and bin 8 (Nyquist) are forced to zero. A constant input frame and an alternating ±A frame therefore both produce an output near zero.
- R7: Outputs whose ideal value lies beyond the 16-bit signed range are clamped to 32767 or -32768.
- R8: The first outValid cycle comes exactly 65 clock edges (N·log2N + 1) after the edge that takes the 16th input sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input sample present |
| inData | input | 16 | Signed input sample |
| inReady | output | 1 | Block is collecting input samples |
| outValid | output | 1 | Output sample present |
| outData | output | 16 | Signed, saturated real part of the transformed sample |
| doneO | output | 1 | Marks the final sample of an output frame |

## Verification
The checker watches the stream framing on every cycle. It checks that input closes after the sixteenth acceptance, that input and output are never open together, that doneO coincides exactly with the sixteenth output, that input reopens right after it, and that the pass latency is fixed. The numerical behaviour can only be shown by the bench's scenarios: the quarter-turn rotation, the zeroed DC and Nyquist bins, the cosine-to-sine mapping and the output clamping. The bench compares every output sample against a floating-point Hilbert transform of the same frame. It uses directed waveforms and seeded random frames with random input gaps.

// File: rtl/hilb_pkg.sv
package hilb_pkg;
  localparam int LOG2N = 4;
  localparam int PTS   = 1 << LOG2N;
  localparam int SW    = 16;
  localparam int TW    = 16;
  localparam int FRAC  = 14;
  localparam int IW    = SW + LOG2N + 1;
  localparam int STW   = (LOG2N > 1) ? $clog2(LOG2N) : 1;
  localparam int TWA   = (LOG2N > 1) ? LOG2N - 1 : 1;
  localparam int LATENCY = PTS * LOG2N + 1;

  typedef enum logic [2:0] {
    ST_LOAD, ST_FWD, ST_ROT, ST_INV, ST_OUT
  } phase_t;

  typedef struct packed {
    logic             loadEn;
    logic             bflyEn;
    logic             inverse;
    logic             rotEn;
    logic [LOG2N-1:0] idx;
    logic [STW-1:0]   stage;
  } dpStrobes_t;
endpackage

// File: rtl/hilb_twiddle_rom.sv
module hilb_twiddle_rom
  import hilb_pkg::*;
(
  input  logic [TWA-1:0]       addr,
  output logic signed [TW-1:0] cosV,
  output logic signed [TW-1:0] sinV
);
  localparam real PI    = 3.14159265358979323846;
  localparam real SCALE = real'(1 << FRAC);

  logic signed [TW-1:0] cosTab [PTS/2];
  logic signed [TW-1:0] sinTab [PTS/2];

  for (genvar gi = 0; gi < PTS/2; gi++) begin : g_tab
    localparam real ANG = 2.0 * PI * gi / PTS;
    localparam real CR  = $cos(ANG) * SCALE;
    localparam real SR  = $sin(ANG) * SCALE;
    localparam int  CV  = (CR >= 0.0) ? $rtoi(CR + 0.5) : -$rtoi(0.5 - CR);
    localparam int  SV  = (SR >= 0.0) ? $rtoi(SR + 0.5) : -$rtoi(0.5 - SR);
    assign cosTab[gi] = TW'(CV);
    assign sinTab[gi] = TW'(SV);
  end

  assign cosV = cosTab[addr];
  assign sinV = sinTab[addr];
endmodule

// File: rtl/hilb_ctrl.sv
module hilb_ctrl
  import hilb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output logic       outValid,
  output logic       doneO,
  output dpStrobes_t strb
);
  localparam logic [LOG2N-1:0] LAST_IDX = LOG2N'(PTS - 1);
  localparam logic [LOG2N-1:0] LAST_BF  = LOG2N'(PTS/2 - 1);
  localparam logic [STW-1:0]   LAST_STG = STW'(LOG2N - 1);

  phase_t           phase;
  logic [LOG2N-1:0] cnt;
  logic [STW-1:0]   stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= ST_LOAD;
      cnt   <= '0;
      stage <= '0;
    end else begin
      case (phase)
        ST_LOAD: if (inValid) begin
          if (cnt == LAST_IDX) begin
            cnt   <= '0;
            stage <= '0;
            phase <= ST_FWD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FWD, ST_INV: begin
          if (cnt == LAST_BF) begin
            cnt <= '0;
            if (stage == LAST_STG) begin
              stage <= '0;
              phase <= (phase == ST_FWD) ? ST_ROT : ST_OUT;
            end else begin
              stage <= stage + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ROT: phase <= ST_INV;
        ST_OUT: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_IDX) phase <= ST_LOAD;
        end
        default: phase <= ST_LOAD;
      endcase
    end
  end

  always_comb begin
    inReady      = (phase == ST_LOAD);
    outValid     = (phase == ST_OUT);
    doneO        = (phase == ST_OUT) && (cnt == LAST_IDX);
    strb.loadEn  = (phase == ST_LOAD) && inValid;
    strb.bflyEn  = (phase == ST_FWD) || (phase == ST_INV);
    strb.inverse = (phase == ST_INV);
    strb.rotEn   = (phase == ST_ROT);
    strb.idx     = cnt;
    strb.stage   = stage;
  end
endmodule

// File: rtl/hilb_datapath.sv
module hilb_datapath
  import hilb_pkg::*;
(
  input  logic                 clk,
  input  dpStrobes_t           strb,
  input  logic signed [SW-1:0] sampleIn,
  output logic signed [SW-1:0] outData
);
  localparam int PW = IW + TW + 1;
  typedef logic signed [PW-1:0] prod_t;
  typedef logic signed [IW:0]   ext_t;
  localparam prod_t RND = prod_t'(1) <<< (FRAC - 1);
  localparam logic signed [IW-1:0] POS_LIM = IW'((1 << (SW - 1)) - 1);
  localparam logic signed [IW-1:0] NEG_LIM = ~POS_LIM;

  logic signed [IW-1:0] bufRe [PTS];
  logic signed [IW-1:0] bufIm [PTS];
  logic signed [IW-1:0] rotRe [PTS];
  logic signed [IW-1:0] rotIm [PTS];

  function automatic logic [LOG2N-1:0] bitRev(input logic [LOG2N-1:0] a);
    logic [LOG2N-1:0] r;
    for (int b = 0; b < LOG2N; b++) r[b] = a[LOG2N-1-b];
    return r;
  endfunction

  // Butterfly addressing for the current stage and butterfly number
  logic [LOG2N-1:0] topIdx, botIdx;
  logic [TWA-1:0]   twIdx;
  always_comb begin
    int s;
    int bf;
    int low;
    s      = int'(strb.stage);
    bf     = int'(strb.idx);
    low    = bf & ((1 << s) - 1);
    topIdx = LOG2N'(((bf >> s) << (s + 1)) | low);
    botIdx = LOG2N'(((bf >> s) << (s + 1)) | low | (1 << s));
    twIdx  = TWA'(low << (LOG2N - 1 - s));
  end

  logic signed [TW-1:0] cosV, sinV, sEff;
  hilb_twiddle_rom u_rom (.addr(twIdx), .cosV(cosV), .sinV(sinV));

  // Complex product b * W, with W conjugated on the inverse pass
  logic signed [IW-1:0] aRe, aIm, bRe, bIm, pRe, pIm;
  logic signed [IW-1:0] topRe, topIm, botRe, botIm;
  prod_t mulRe, mulIm;
  ext_t  sumRe, sumIm, difRe, difIm;

  always_comb begin
    aRe   = bufRe[topIdx];
    aIm   = bufIm[topIdx];
    bRe   = bufRe[botIdx];
    bIm   = bufIm[botIdx];
    sEff  = strb.inverse ? -sinV : sinV;
    mulRe = prod_t'(bRe) * prod_t'(cosV) + prod_t'(bIm) * prod_t'(sEff);
    mulIm = prod_t'(bIm) * prod_t'(cosV) - prod_t'(bRe) * prod_t'(sEff);
    pRe   = IW'((mulRe + RND) >>> FRAC);
    pIm   = IW'((mulIm + RND) >>> FRAC);
    sumRe = ext_t'(aRe) + ext_t'(pRe);
    sumIm = ext_t'(aIm) + ext_t'(pIm);
    difRe = ext_t'(aRe) - ext_t'(pRe);
    difIm = ext_t'(aIm) - ext_t'(pIm);
    if (strb.inverse) begin
      topRe = IW'(sumRe);
      topIm = IW'(sumIm);
      botRe = IW'(difRe);
      botIm = IW'(difIm);
    end else begin
      topRe = IW'((sumRe + ext_t'(1)) >>> 1);
      topIm = IW'((sumIm + ext_t'(1)) >>> 1);
      botRe = IW'((difRe + ext_t'(1)) >>> 1);
      botIm = IW'((difIm + ext_t'(1)) >>> 1);
    end
  end

  // Quarter-turn per bin: -j above zero, +j below, DC and Nyquist cleared
  for (genvar k = 0; k < PTS; k++) begin : g_rot
    if (k == 0 || k == PTS/2) begin : g_zero
      assign rotRe[k] = '0;
      assign rotIm[k] = '0;
    end else if (k < PTS/2) begin : g_pos
      assign rotRe[k] = bufIm[k];
      assign rotIm[k] = -bufRe[k];
    end else begin : g_neg
      assign rotRe[k] = -bufIm[k];
      assign rotIm[k] = bufRe[k];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.rotEn) begin
      for (int k = 0; k < PTS; k++) begin
        bufRe[bitRev(LOG2N'(k))] <= rotRe[k];
        bufIm[bitRev(LOG2N'(k))] <= rotIm[k];
      end
    end else if (strb.bflyEn) begin
      bufRe[topIdx] <= topRe;
      bufIm[topIdx] <= topIm;
      bufRe[botIdx] <= botRe;
      bufIm[botIdx] <= botIm;
    end else if (strb.loadEn) begin
      bufRe[bitRev(strb.idx)] <= IW'(sampleIn);
      bufIm[bitRev(strb.idx)] <= '0;
    end
  end

  logic signed [IW-1:0] sel;
  always_comb begin
    sel = bufRe[strb.idx];
    if (sel > POS_LIM)      outData = {1'b0, {(SW-1){1'b1}}};
    else if (sel < NEG_LIM) outData = {1'b1, {(SW-1){1'b0}}};
    else                    outData = SW'(sel);
  end
endmodule

// File: rtl/hilbert_fft.sv
module hilbert_fft
  import hilb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic signed [SW-1:0] inData,
  output logic                 inReady,
  output logic                 outValid,
  output logic signed [SW-1:0] outData,
  output logic                 doneO
);
  dpStrobes_t strb;

  hilb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .doneO(doneO), .strb(strb)
  );

  hilb_datapath u_dp (
    .clk(clk), .strb(strb), .sampleIn(inData), .outData(outData)
  );
endmodule

// File: rtl/hilbert_fft_chk.sv
module hilbert_fft_chk
  import hilb_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic outValid,
  input logic doneO
);
  logic [LOG2N-1:0] accCnt, outCnt;
  logic [15:0]      latCnt;
  logic             timing;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accCnt <= '0;
      outCnt <= '0;
      latCnt <= '0;
      timing <= 1'b0;
    end else begin
      if (inValid && inReady) accCnt <= accCnt + 1'b1;
      if (outValid) outCnt <= outCnt + 1'b1;
      if (inValid && inReady && accCnt == LOG2N'(PTS - 1)) begin
        latCnt <= '0;
        timing <= 1'b1;
      end else if (outValid) begin
        timing <= 1'b0;
      end else if (timing) begin
        latCnt <= latCnt + 1'b1;
      end
    end
  end

  // R2
  accept_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && accCnt == LOG2N'(PTS - 1)) |=> !inReady);

  // R2
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  // R3
  done_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> (outValid && outCnt == LOG2N'(PTS - 1)));

  // R3
  last_has_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCnt == LOG2N'(PTS - 1)) |-> doneO);

  // R2
  reopen_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> (!outValid && inReady));

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (latCnt == 16'(LATENCY)));
endmodule

bind hilbert_fft hilbert_fft_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .doneO(doneO)
);

// File: tb/hilbert_fft_tb_top.sv
`timescale 1ns/1ps
module hilbert_fft_tb_top;
  import hilb_pkg::*;

  localparam int NP  = PTS;
  localparam int TOL = 40;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [SW-1:0] inData = '0;
  logic inReady, outValid, doneO;
  logic signed [SW-1:0] outData;

  int checks = 0;
  int fails  = 0;
  int xs   [NP];
  int expv [NP];
  int got  [NP];

  always #2.5 clk = ~clk;

  hilbert_fft dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outData(outData), .doneO(doneO)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Floating-point Hilbert transform of xs, rounded and clamped (R4, R6, R7)
  function automatic void computeExp();
    real yr [NP];
    real yi [NP];
    for (int k = 0; k < NP; k++) begin
      real xr = 0.0;
      real xi = 0.0;
      for (int n = 0; n < NP; n++) begin
        real a = 2.0 * PI * k * n / NP;
        xr += xs[n] * $cos(a);
        xi -= xs[n] * $sin(a);
      end
      if (k > 0 && k < NP/2) begin yr[k] = xi;  yi[k] = -xr; end
      else if (k > NP/2)     begin yr[k] = -xi; yi[k] = xr;  end
      else                   begin yr[k] = 0.0; yi[k] = 0.0; end
    end
    for (int n = 0; n < NP; n++) begin
      real acc = 0.0;
      for (int k = 0; k < NP; k++) begin
        real a = 2.0 * PI * k * n / NP;
        acc += yr[k] * $cos(a) - yi[k] * $sin(a);
      end
      acc = acc / NP;
      if (acc > 32767.0)       expv[n] = 32767;
      else if (acc < -32768.0) expv[n] = -32768;
      else                     expv[n] = $rtoi(acc + ((acc >= 0.0) ? 0.5 : -0.5));
    end
  endfunction

  task automatic runBlock(input string tag, input bit gaps);
    int i;
    int lat;
    computeExp();
    i = 0;
    while (i < NP) begin
      @(negedge clk);
      chk(inReady == 1'b1, "R2", "inReady while collecting", int'(inReady), 1);
      if (gaps && $urandom_range(3) == 0) begin
        inValid = 1'b0;
        inData  = SW'($urandom);
      end else begin
        inValid = 1'b1;
        inData  = SW'(xs[i]);
      end
      @(posedge clk);
      if (inValid) i++;
    end
    lat = 0;
    while (1) begin
      @(negedge clk);
      inValid = 1'b0;
      if (lat == 0) chk(inReady == 1'b0, "R2", "inReady after last sample", int'(inReady), 0);
      if (outValid || lat > 200) break;
      @(posedge clk);
      lat++;
    end
    chk(lat == LATENCY, "R8", "output latency", lat, LATENCY);
    for (int n = 0; n < NP; n++) begin
      got[n] = int'(outData);
      chk(outValid == 1'b1, "R3", "outValid within frame", int'(outValid), 1);
      chk(doneO == (n == NP - 1), "R3", "doneO position", int'(doneO), int'(n == NP - 1));
      @(negedge clk);
    end
    chk(outValid == 1'b0, "R3", "outValid after frame", int'(outValid), 0);
    chk(inReady == 1'b1, "R2", "inReady reopened", int'(inReady), 1);
    for (int n = 0; n < NP; n++) begin
      int d = got[n] - expv[n];
      if (d < 0) d = -d;
      chk(d <= TOL, tag, $sformatf("sample %0d", n), got[n], expv[n]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(inReady == 1'b1, "R1", "inReady in reset", int'(inReady), 1);
    chk(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    chk(doneO == 1'b0, "R1", "doneO in reset", int'(doneO), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(inReady == 1'b1 && outValid == 1'b0, "R1", "state after reset",
        int'({inReady, outValid}), 2);

    // R5: cosines map to sines
    for (int n = 0; n < NP; n++) xs[n] = $rtoi(20000.0 * $cos(2.0 * PI * 3 * n / NP));
    runBlock("R5", 1'b0);
    for (int n = 0; n < NP; n++) begin
      int d = expv[n] - $rtoi(20000.0 * $sin(2.0 * PI * 3 * n / NP));
      if (d < 0) d = -d;
      chk(d <= 2, "R5", "reference sine", expv[n], $rtoi(20000.0 * $sin(2.0 * PI * 3 * n / NP)));
    end
    for (int n = 0; n < NP; n++) xs[n] = $rtoi(-15000.0 * $cos(2.0 * PI * 1 * n / NP));
    runBlock("R5", 1'b0);
    for (int n = 0; n < NP; n++) xs[n] = $rtoi(25000.0 * $cos(2.0 * PI * 7 * n / NP));
    runBlock("R5", 1'b0);

    // R6: DC and Nyquist removed
    for (int n = 0; n < NP; n++) xs[n] = 9000;
    runBlock("R6", 1'b0);
    for (int n = 0; n < NP; n++) xs[n] = (n % 2 == 0) ? 9000 : -9000;
    runBlock("R6", 1'b0);

    // R4: impulse
    for (int n = 0; n < NP; n++) xs[n] = (n == 0) ? 30000 : 0;
    runBlock("R4", 1'b0);

    // R7: full-scale square wave drives the ideal output past the range
    for (int n = 0; n < NP; n++) xs[n] = (n < NP/2) ? 32767 : -32768;
    runBlock("R7", 1'b0);
    chk(expv[0] == -32768 || expv[NP/2] == 32767 || expv[0] == 32767 || expv[NP/2] == -32768,
        "R7", "square frame reaches clamp", expv[0], -32768);

    // R4: seeded random frames with input gaps
    for (int b = 0; b < 8; b++) begin
      for (int n = 0; n < NP; n++) xs[n] = int'($urandom_range(24000)) - 12000;
      runBlock("R4", 1'b1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule